// File: doc/BRIEF.md
# Bit-Serial Pass-Through Reduction Unit

This unit sits at a node with eight bit-serial links and performs global reductions without first collecting whole words. Each incoming bit is combined as soon as it arrives and the result bit goes out on the next clock. A chain of such nodes therefore adds only one cycle of delay per hop. In sum mode the unit adds a chosen subset of the links and a local word. In max mode it picks the unsigned maximum of the same kind of operand set. In broadcast mode it repeats one chosen link onto a set of output links and keeps a copy of the received word.

A sum leaves a small carry behind when it finishes. That carry is added into the next sum, so a sequence of 32-bit sums, sent from the lowest word to the highest, builds a result of any precision. A clear control zeroes the carry before a new extended sum. Link framing, acknowledgements and retries are handled elsewhere. The inputs arrive as framed, aligned bit streams. The unit checks that every selected source starts in the same cycle. If they do not, it flags an error and suppresses that frame.

Top module: `rdx_passthru`

## Requirements
- R1: `cfg_mode` selects the function: 0 = off, 1 = sum, 2 = max, 3 = broadcast. In off mode no start bit is accepted and `link_out` stays all zero.
- R2: A frame on a link is one start bit of value 1 followed by 32 data bits, and the line is 0 when idle. The output start bit appears on `link_out` in the cycle after the input start bit is sampled. Output data bit k appears in the cycle after input data bit k is sampled.
- R3: In sum mode, links whose `cfg_in_mask` bit i is 1 (bit i = link i) are added together with `cfg_local_word` and the stored carry, least significant bit first. The low 32 bits of the result are sent only on link `cfg_out_sel`, and every other output link stays 0.
- R4: At the end of a sum frame the carry out of bit 31 is kept, with a value from 0 to 8, and added at bit 0 of the next sum frame. Holding `cfg_clear_carry` high for a cycle while no frame is active sets the kept carry to 0.
- R5: In max mode the selected links and `cfg_local_word` are compared as unsigned values, most significant bit first. The maximum is sent most significant bit first, only on link `cfg_out_sel`, and a tie gives the shared value.
- R6: In broadcast mode the frame on link `cfg_in_sel` is repeated, least significant bit first, on every link whose `cfg_out_mask` bit is 1, and `cfg_in_mask` has no effect. The received word appears on `bcast_word`, and `bcast_done` is high for one cycle, in the cycle after the last data bit is sampled.
- R7: Links that are not selected as inputs have no effect, including their start bits and their timing.
- R8: If the selected links do not all present their start bit in the same cycle, `align_err` is high for exactly one cycle, the cycle after the first start bit. No link carries any output for that frame, and inputs are ignored for the following 33 cycles. After that a correctly aligned frame is handled normally.
- R9: After reset, `link_out` is all zero, `align_err` and `bcast_done` are 0, and the kept carry is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 2 | Function select: 0 off, 1 sum, 2 max, 3 broadcast |
| cfg_in_mask | input | 8 | Source links for sum and max |
| cfg_in_sel | input | 3 | Source link for broadcast |
| cfg_out_sel | input | 3 | Destination link for sum and max |
| cfg_out_mask | input | 8 | Destination links for broadcast |
| cfg_local_word | input | 32 | Local operand for sum and max |
| cfg_clear_carry | input | 1 | Zeroes the kept carry while idle |
| link_in | input | 8 | Serial input bit of each link |
| link_out | output | 8 | Serial output bit of each link |
| align_err | output | 1 | One-cycle pulse on misaligned start bits |
| bcast_word | output | 32 | Last word received in broadcast mode |
| bcast_done | output | 1 | One-cycle pulse when a broadcast word is complete |

## Verification
The extended-precision case sums eight all-ones links with an all-ones local word. This leaves a carry of 8, which must come out as the value 8 in the next frame of zeros and then vanish after a clear. A design with a narrow carry register, or one that reset the carry at every frame, would give a wrong second word. Max mode is tested with ties, with the local word winning and with alternating link selections. A design that dropped candidates wrongly, or that sent bits in the wrong order, would output a smaller or bit-reversed value. A selected link started one cycle late must raise the error and silence every output. A late start on an unselected link must change nothing. A design without the drain period would later treat the late link's data bits as a new start.

// File: rtl/rdx_pkg.sv
package rdx_pkg;
    localparam int NLINK  = 8;
    localparam int LSEL_W = $clog2(NLINK);
    localparam int NOPS   = NLINK + 1;
    localparam int CRY_W  = $clog2(NOPS);

    typedef enum logic [1:0] {
        MODE_OFF   = 2'd0,
        MODE_SUM   = 2'd1,
        MODE_MAX   = 2'd2,
        MODE_BCAST = 2'd3
    } rdx_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2
    } rdx_state_e;

    typedef struct packed {
        rdx_mode_e        mode;
        logic [NLINK-1:0] src;
        logic [NLINK-1:0] dst;
    } rdx_route_t;

    function automatic logic [NLINK-1:0] sel_onehot(input logic [LSEL_W-1:0] idx);
        logic [NLINK-1:0] v;
        v      = '0;
        v[idx] = 1'b1;
        return v;
    endfunction

    function automatic logic [CRY_W:0] ones_count(input logic [NOPS-1:0] v);
        logic [CRY_W:0] n;
        n = '0;
        for (int i = 0; i < NOPS; i++) n = n + {{CRY_W{1'b0}}, v[i]};
        return n;
    endfunction
endpackage

// File: rtl/rdx_frame_ctl.sv
module rdx_frame_ctl
    import rdx_pkg::*;
#(
    parameter int W = 32,
    localparam int CNT_W = $clog2(W + 1),
    localparam int IDX_W = $clog2(W)
) (
    input  logic             clk,
    input  logic             rst,
    input  rdx_route_t       live,
    input  logic [NLINK-1:0] link_in,
    output rdx_route_t       route,
    output logic             start_fire,
    output logic             run,
    output logic             last,
    output logic             drain,
    output logic             err,
    output logic [IDX_W-1:0] bit_pos
);
    rdx_state_e       state;
    logic [CNT_W-1:0] cnt;
    rdx_route_t       lat;
    logic [NLINK-1:0] starts;
    logic             misalign;

    assign starts     = live.src & link_in;
    assign start_fire = (state == ST_IDLE) && (live.src != '0) && (starts == live.src);
    assign misalign   = (state == ST_IDLE) && (starts != '0) && (starts != live.src);
    assign run        = (state == ST_RUN);
    assign drain      = (state == ST_DRAIN);
    assign last       = run && (cnt == CNT_W'(W - 1));
    assign route      = (state == ST_IDLE) ? live : lat;
    assign bit_pos    = cnt[IDX_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
            lat   <= '0;
            err   <= 1'b0;
        end else begin
            err <= misalign;
            case (state)
                ST_IDLE: begin
                    cnt <= '0;
                    if (start_fire) begin
                        state <= ST_RUN;
                        lat   <= live;
                    end else if (misalign) begin
                        state <= ST_DRAIN;
                    end
                end
                ST_RUN: begin
                    if (cnt == CNT_W'(W - 1)) state <= ST_IDLE;
                    else cnt <= cnt + 1'b1;
                end
                ST_DRAIN: begin
                    if (cnt == CNT_W'(W)) state <= ST_IDLE;
                    else cnt <= cnt + 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R8: an error pulse is always accompanied by the drain period
    a_r8_err_drains: assert property (@(posedge clk) disable iff (rst) err |-> drain);
endmodule

// File: rtl/rdx_sum_slice.sv
module rdx_sum_slice
    import rdx_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            clear,
    input  logic            step,
    input  logic [NOPS-1:0] ops,
    output logic            sum_bit
);
    logic [CRY_W-1:0] carry;
    logic [CRY_W:0]   total;

    assign total   = ones_count(ops) + {1'b0, carry};
    assign sum_bit = total[0];

    always_ff @(posedge clk) begin
        if (rst || clear) carry <= '0;
        else if (step)    carry <= total[CRY_W:1];
    end

    // R4: the kept carry never exceeds the operand count minus one
    a_r4_carry_bound: assert property (@(posedge clk) disable iff (rst)
        carry <= CRY_W'(NOPS - 1));
endmodule

// File: rtl/rdx_max_slice.sv
module rdx_max_slice
    import rdx_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic [NOPS-1:0] init,
    input  logic            step,
    input  logic            last,
    input  logic [NOPS-1:0] ops,
    output logic            max_bit
);
    logic [NOPS-1:0] cand;
    logic [NOPS-1:0] ones;

    assign ones    = cand & ops;
    assign max_bit = |ones;

    always_ff @(posedge clk) begin
        if (rst)                   cand <= '0;
        else if (load)             cand <= init;
        else if (step && max_bit)  cand <= ones;
    end

    // R5: candidates only ever drop out during a frame
    a_r5_cand_shrink: assert property (@(posedge clk) disable iff (rst)
        (step && !last) |=> ((cand & ~$past(cand)) == '0));
endmodule

// File: rtl/rdx_out_steer.sv
module rdx_out_steer
    import rdx_pkg::*;
#(
    parameter int W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  rdx_route_t       route,
    input  logic             start_fire,
    input  logic             run,
    input  logic             last,
    input  logic             sum_bit,
    input  logic             max_bit,
    input  logic             bc_bit,
    output logic [NLINK-1:0] link_out,
    output logic [W-1:0]     bcast_word,
    output logic             bcast_done
);
    logic res_bit;

    always_comb begin
        case (route.mode)
            MODE_SUM:   res_bit = sum_bit;
            MODE_MAX:   res_bit = max_bit;
            MODE_BCAST: res_bit = bc_bit;
            default:    res_bit = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            link_out   <= '0;
            bcast_word <= '0;
            bcast_done <= 1'b0;
        end else begin
            if (start_fire)  link_out <= route.dst;
            else if (run)    link_out <= route.dst & {NLINK{res_bit}};
            else             link_out <= '0;
            if (run && route.mode == MODE_BCAST)
                bcast_word <= {bc_bit, bcast_word[W-1:1]};
            bcast_done <= run && last && (route.mode == MODE_BCAST);
        end
    end

    // R2: the output start bit follows the input start by one cycle
    a_r2_start_next: assert property (@(posedge clk) disable iff (rst)
        (start_fire && route.dst != '0) |=> (link_out == $past(route.dst)));
    // R6: completion is only signalled right after a running frame
    a_r6_done_after_run: assert property (@(posedge clk) disable iff (rst)
        bcast_done |-> $past(run));
endmodule

// File: rtl/rdx_passthru.sv
module rdx_passthru
    import rdx_pkg::*;
#(
    parameter int W = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [1:0]           cfg_mode,
    input  logic [NLINK-1:0]     cfg_in_mask,
    input  logic [LSEL_W-1:0]    cfg_in_sel,
    input  logic [LSEL_W-1:0]    cfg_out_sel,
    input  logic [NLINK-1:0]     cfg_out_mask,
    input  logic [W-1:0]         cfg_local_word,
    input  logic                 cfg_clear_carry,
    input  logic [NLINK-1:0]     link_in,
    output logic [NLINK-1:0]     link_out,
    output logic                 align_err,
    output logic [W-1:0]         bcast_word,
    output logic                 bcast_done
);
    localparam int IDX_W = $clog2(W);

    rdx_route_t       live, route;
    rdx_mode_e        mode_in;
    logic             start_fire, run, last, drain;
    logic [IDX_W-1:0] bit_pos, msb_pos;
    logic             local_bit, sum_bit, max_bit, bc_bit;
    logic [NOPS-1:0]  ops;

    assign mode_in = rdx_mode_e'(cfg_mode);

    always_comb begin
        live.mode = mode_in;
        case (mode_in)
            MODE_SUM, MODE_MAX: begin
                live.src = cfg_in_mask;
                live.dst = sel_onehot(cfg_out_sel);
            end
            MODE_BCAST: begin
                live.src = sel_onehot(cfg_in_sel);
                live.dst = cfg_out_mask;
            end
            default: begin
                live.src = '0;
                live.dst = '0;
            end
        endcase
    end

    rdx_frame_ctl #(.W(W)) u_ctl (
        .clk(clk), .rst(rst), .live(live), .link_in(link_in),
        .route(route), .start_fire(start_fire), .run(run), .last(last),
        .drain(drain), .err(align_err), .bit_pos(bit_pos)
    );

    assign msb_pos   = IDX_W'(W - 1) - bit_pos;
    assign local_bit = (route.mode == MODE_MAX) ? cfg_local_word[msb_pos]
                                                : cfg_local_word[bit_pos];
    assign ops       = {local_bit, link_in & route.src};
    assign bc_bit    = |(link_in & route.src);

    rdx_sum_slice u_sum (
        .clk(clk), .rst(rst),
        .clear(cfg_clear_carry && !run && !drain),
        .step(run && route.mode == MODE_SUM),
        .ops(ops), .sum_bit(sum_bit)
    );

    rdx_max_slice u_max (
        .clk(clk), .rst(rst),
        .load(start_fire && route.mode == MODE_MAX),
        .init({1'b1, route.src}),
        .step(run && route.mode == MODE_MAX),
        .last(last), .ops(ops), .max_bit(max_bit)
    );

    rdx_out_steer #(.W(W)) u_steer (
        .clk(clk), .rst(rst), .route(route), .start_fire(start_fire),
        .run(run), .last(last), .sum_bit(sum_bit), .max_bit(max_bit),
        .bc_bit(bc_bit), .link_out(link_out), .bcast_word(bcast_word),
        .bcast_done(bcast_done)
    );

    // R8: nothing leaves the node while a bad frame drains
    a_r8_drain_silent: assert property (@(posedge clk) disable iff (rst)
        drain |-> (link_out == '0));
    // R3: a reduction result drives at most one link
    a_r3_single_link: assert property (@(posedge clk) disable iff (rst)
        (run && route.mode != MODE_BCAST) |-> $onehot0(link_out));
endmodule

// File: tb/rdx_passthru_test.sv
module rdx_passthru_test;
    localparam int W = 32;
    localparam int NL = 8;
    localparam int FR = W + 2;

    typedef struct packed {
        logic [1:0]  mode;
        logic [7:0]  imask;
        logic [2:0]  isel;
        logic [2:0]  osel;
        logic [7:0]  omask;
        logic [31:0] lw;
        logic [7:0]  seed;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{2'd1, 8'h06, 3'd0, 3'd5, 8'h00, 32'h0000_0003, 8'd1},
        '{2'd1, 8'h7F, 3'd0, 3'd7, 8'h00, 32'h1234_5678, 8'd2},
        '{2'd2, 8'hAA, 3'd0, 3'd0, 8'h00, 32'h0000_0010, 8'd3},
        '{2'd2, 8'h01, 3'd0, 3'd3, 8'h00, 32'hFFFF_0000, 8'd4},
        '{2'd3, 8'hFF, 3'd2, 3'd0, 8'hC5, 32'h0000_0000, 8'd5},
        '{2'd3, 8'h00, 3'd7, 3'd0, 8'hFF, 32'h0000_0000, 8'd6},
        '{2'd1, 8'h81, 3'd0, 3'd0, 8'h00, 32'h0000_0000, 8'd7}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  mode_r = 2'd0;
    logic [7:0]  imask_r = '0, omask_r = '0, lin = '0;
    logic [2:0]  isel_r = '0, osel_r = '0;
    logic [31:0] lw_r = '0;
    logic        clr_r = 1'b0;
    logic [7:0]  lout;
    logic        aerr, bdone;
    logic [31:0] bword;

    logic [31:0] words [NL];
    logic [7:0]  cap [FR];
    logic        err_at [FR];
    logic        done_at [FR];
    logic [31:0] bw_at [FR];
    logic [63:0] exp_carry = '0;
    int n_chk = 0, n_bad = 0;

    always #10 clk = ~clk;

    rdx_passthru #(.W(W)) uut (
        .clk(clk), .rst(rst), .cfg_mode(mode_r), .cfg_in_mask(imask_r),
        .cfg_in_sel(isel_r), .cfg_out_sel(osel_r), .cfg_out_mask(omask_r),
        .cfg_local_word(lw_r), .cfg_clear_carry(clr_r), .link_in(lin),
        .link_out(lout), .align_err(aerr), .bcast_word(bword), .bcast_done(bdone)
    );

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    function automatic logic [31:0] gen_word(input int seed, input int l);
        logic [31:0] s, k;
        s = 32'(seed);
        k = 32'(l);
        return (s * 32'h9E37_79B1) ^ (k * 32'h7F4A_7C15 + s * 32'd977 + k * s);
    endfunction

    function automatic logic [7:0] dst_mask();
        case (mode_r)
            2'd1, 2'd2: return 8'(1) << osel_r;
            2'd3:       return omask_r;
            default:    return 8'h00;
        endcase
    endfunction

    task automatic calc_expect(output logic [31:0] res);
        logic [63:0] t;
        res = '0;
        case (mode_r)
            2'd1: begin
                t = exp_carry + {32'd0, lw_r};
                for (int l = 0; l < NL; l++) if (imask_r[l]) t = t + {32'd0, words[l]};
                res = t[31:0];
                exp_carry = t >> 32;
            end
            2'd2: begin
                res = lw_r;
                for (int l = 0; l < NL; l++) if (imask_r[l] && words[l] > res) res = words[l];
            end
            2'd3: res = words[isel_r];
            default: res = '0;
        endcase
    endtask

    task automatic send_frame(input int skew);
        logic [7:0] v;
        int k;
        for (int j = 0; j < FR; j++) begin
            for (int l = 0; l < NL; l++) begin
                k = (l == skew) ? j - 1 : j;
                if (k == 0) v[l] = 1'b1;
                else if (k >= 1 && k <= W)
                    v[l] = (mode_r == 2'd2) ? words[l][W - k] : words[l][k - 1];
                else v[l] = 1'b0;
            end
            lin = v;
            @(posedge clk); #1;
            cap[j] = lout; err_at[j] = aerr; done_at[j] = bdone; bw_at[j] = bword;
        end
        lin = '0;
        repeat (3) @(posedge clk);
        #1;
    endtask

    function automatic logic [31:0] extract(input int l);
        logic [31:0] g;
        for (int d = 0; d < W; d++) begin
            if (mode_r == 2'd2) g[W - 1 - d] = cap[d + 1][l];
            else g[d] = cap[d + 1][l];
        end
        return g;
    endfunction

    task automatic frame_check(input string tag, input int skew);
        logic [31:0] exp;
        logic [7:0]  dm, stray;
        int dn;
        dm = dst_mask();
        calc_expect(exp);
        send_frame(skew);
        chk({tag, " R2 start bit one cycle after input start"}, 64'(cap[0]), 64'(dm));
        stray = '0;
        for (int j = 1; j < FR; j++) stray = stray | (cap[j] & ~dm);
        chk({tag, " R3 unselected outputs silent"}, 64'(stray), 64'd0);
        for (int l = 0; l < NL; l++)
            if (dm[l]) chk({tag, " result word on output"}, 64'(extract(l)), 64'(exp));
        if (mode_r == 2'd3) begin
            dn = 0;
            for (int j = 0; j < FR; j++) dn += int'(done_at[j]);
            chk({tag, " R6 bcast_done at last bit"}, {63'd0, done_at[W]}, 64'd1);
            chk({tag, " R6 single done pulse"}, 64'(dn), 64'd1);
            chk({tag, " R6 stored word"}, 64'(bw_at[W]), 64'(exp));
        end
    endtask

    task automatic clear_carry();
        clr_r = 1'b1;
        @(posedge clk); #1;
        clr_r = 1'b0;
        exp_carry = '0;
    endtask

    initial begin
        #4_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        string tg;
        logic [7:0] any;
        int ne;
        repeat (3) @(posedge clk);
        #1; rst = 1'b0;
        chk("R9 link_out after reset", 64'(lout), 64'd0);
        chk("R9 align_err after reset", {63'd0, aerr}, 64'd0);
        chk("R9 bcast_done after reset", {63'd0, bdone}, 64'd0);

        // table of vectors; words on unselected links act as R7 noise
        for (int v = 0; v < NV; v++) begin
            mode_r = VECS[v].mode; imask_r = VECS[v].imask; isel_r = VECS[v].isel;
            osel_r = VECS[v].osel; omask_r = VECS[v].omask; lw_r = VECS[v].lw;
            for (int l = 0; l < NL; l++) words[l] = gen_word(int'(VECS[v].seed), l);
            tg = (mode_r == 2'd1) ? "R3 R4 sum" : (mode_r == 2'd2) ? "R5 max" : "R6 R7 bcast";
            frame_check(tg, -1);
        end

        // R1 off mode sends nothing
        mode_r = 2'd0; imask_r = 8'hFF;
        for (int l = 0; l < NL; l++) words[l] = 32'hDEAD_0000 + 32'(l);
        send_frame(-1);
        any = '0;
        for (int j = 0; j < FR; j++) any = any | cap[j];
        chk("R1 off mode silent", 64'(any), 64'd0);

        // R4 extended precision chain
        clear_carry();
        mode_r = 2'd1; imask_r = 8'hFF; osel_r = 3'd2; lw_r = 32'hFFFF_FFFF;
        for (int l = 0; l < NL; l++) words[l] = 32'hFFFF_FFFF;
        frame_check("R4 all-ones low word", -1);
        chk("R4 bench carry is 8", exp_carry, 64'd8);
        lw_r = '0;
        for (int l = 0; l < NL; l++) words[l] = '0;
        frame_check("R4 carry into next word", -1);
        clear_carry();
        frame_check("R4 after clear", -1);

        // R5 tie
        mode_r = 2'd2; imask_r = 8'h3C; osel_r = 3'd6; lw_r = 32'h0000_0001;
        for (int l = 0; l < NL; l++) words[l] = (l >= 2 && l <= 5) ? 32'h8000_7777 : 32'hFFFF_FFFF;
        frame_check("R5 R7 tie", -1);

        // R8 misaligned selected link
        mode_r = 2'd1; imask_r = 8'h03; osel_r = 3'd4; lw_r = 32'd5;
        for (int l = 0; l < NL; l++) words[l] = gen_word(11, l);
        send_frame(1);
        any = '0; ne = 0;
        for (int j = 0; j < FR; j++) begin any = any | cap[j]; ne += int'(err_at[j]); end
        chk("R8 align_err cycle after start", {63'd0, err_at[0]}, 64'd1);
        chk("R8 single err pulse", 64'(ne), 64'd1);
        chk("R8 no output on bad frame", 64'(any), 64'd0);
        frame_check("R8 recovery frame", -1);

        // R7 late start on an unselected link is harmless
        frame_check("R7 unselected skew", 5);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule